// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the program counter state of an in-order core whose architecture has exactly one branch delay slot. It keeps two registers: the address of the instruction now executing (PC) and the address of the one that runs after it (nPC). Each clock, PC takes the old nPC. nPC either advances by one instruction width or, when the current instruction transfers control, takes the transfer target. Because the target goes into nPC and not into PC, the instruction right after every branch or jump always executes, and the redirect shows up one instruction later.

The decoder supplies a 4-bit transfer code together with the two register operands, a 16-bit word offset and a 26-bit jump index. The sequencer evaluates the branch condition from the operands alone, since there are no condition codes. It forms the target and drives the fetch address. For the linking forms it also asks for a write of the return address into the link register. The return address is the instruction after the delay slot.

Top module: `dbr_pc_seq`

## Requirements
- R1: While reset is low, the fetch address is 0. After reset is released, the first clock moves the fetch address to 4, because nPC resets to 4.
- R2: On every clock out of reset, the fetch address becomes the previous nPC. Codes 0 (sequential) and the unused codes 13, 14 and 15 never redirect, so nPC advances by 4.
- R3: The conditional codes and their tests on the two operands, all signed: 1 taken when operand A equals B; 2 taken when they differ; 3 taken when A <= 0; 4 taken when A > 0; 5 and 7 taken when A < 0; 6 and 8 taken when A >= 0.
- R4: A taken conditional branch loads nPC with nPC plus the offset, sign-extended and shifted left by 2. A branch that is not taken loads nPC + 4. Either way the delay-slot instruction is fetched next.
- R5: Codes 7, 8, 10 and 12 raise link_we in the same cycle. With it, link_rd is 31 and link_val is nPC + 4, which is the address after the delay slot. Codes 7 and 8 link even when they are not taken.
- R6: Codes 9 and 10 load nPC with bits 31..28 of the current nPC, followed by the 26-bit index, followed by two zero bits.
- R7: Codes 11 and 12 load nPC with operand A, with its low two bits cleared.
- R8: A transfer placed in a delay slot computes its target from the nPC at that moment. That nPC is the first transfer's target.
- R9: Every code other than 7, 8, 10 and 12 keeps link_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_op | input | 4 | Transfer code of the instruction at fetch_pc |
| opnd_a | input | 32 | First register operand / register jump target |
| opnd_b | input | 32 | Second register operand |
| br_ofs | input | 16 | Signed branch word offset |
| jmp_idx | input | 26 | Absolute jump word index |
| fetch_pc | output | 32 | Address of the instruction executing now |
| link_we | output | 1 | Return-address write request |
| link_val | output | 32 | Return address |
| link_rd | output | 5 | Destination register of the return address |

## Verification
The bench builds the block with a 32-bit address, 4-byte instructions, a 16-bit offset, a 26-bit jump index and link register 31. These are the values where the upper four region bits survive an absolute jump and where the most negative offset reaches 128 KiB backwards. At this width the sign bit of 0x8000_0000 separates the less-than-zero tests from the greater-or-equal tests. Chains of transfers in delay slots show that nPC, and not PC, is the base for each target.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

   // transfer codes as delivered by the decoder
   typedef enum logic [3:0] {
      XF_SEQ    = 4'd0,
      XF_BEQ    = 4'd1,
      XF_BNE    = 4'd2,
      XF_BLEZ   = 4'd3,
      XF_BGTZ   = 4'd4,
      XF_BLTZ   = 4'd5,
      XF_BGEZ   = 4'd6,
      XF_BLTZL  = 4'd7,
      XF_BGEZL  = 4'd8,
      XF_JABS   = 4'd9,
      XF_JABSL  = 4'd10,
      XF_JREG   = 4'd11,
      XF_JREGL  = 4'd12
   } xfer_e;

   // which source feeds nPC
   typedef enum logic [1:0] {
      TS_SEQ = 2'd0,
      TS_REL = 2'd1,
      TS_ABS = 2'd2,
      TS_REG = 2'd3
   } tsel_e;

endpackage

// File: rtl/dbr_cond.sv
module dbr_cond #(
   parameter int XLEN = 32
) (
   input  logic [3:0]      xfer_i,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   output dbr_pkg::tsel_e  tsel_o,
   output logic            link_o
);
   import dbr_pkg::*;

   logic a_eq_b;
   logic a_neg;
   logic a_zero;
   logic a_lez;
   logic a_gtz;

   assign a_eq_b = (opnd_a == opnd_b);
   assign a_neg  = opnd_a[XLEN-1];
   assign a_zero = (opnd_a == '0);
   assign a_lez  = a_neg | a_zero;
   assign a_gtz  = ~a_neg & ~a_zero;

   always_comb begin
      tsel_o = TS_SEQ;
      link_o = 1'b0;
      case (xfer_i)
         XF_BEQ:   if (a_eq_b)  tsel_o = TS_REL;
         XF_BNE:   if (!a_eq_b) tsel_o = TS_REL;
         XF_BLEZ:  if (a_lez)   tsel_o = TS_REL;
         XF_BGTZ:  if (a_gtz)   tsel_o = TS_REL;
         XF_BLTZ:  if (a_neg)   tsel_o = TS_REL;
         XF_BGEZ:  if (!a_neg)  tsel_o = TS_REL;
         XF_BLTZL: begin
            link_o = 1'b1;
            if (a_neg) tsel_o = TS_REL;
         end
         XF_BGEZL: begin
            link_o = 1'b1;
            if (!a_neg) tsel_o = TS_REL;
         end
         XF_JABS:  tsel_o = TS_ABS;
         XF_JABSL: begin
            link_o = 1'b1;
            tsel_o = TS_ABS;
         end
         XF_JREG:  tsel_o = TS_REG;
         XF_JREGL: begin
            link_o = 1'b1;
            tsel_o = TS_REG;
         end
         default:  tsel_o = TS_SEQ;
      endcase
   end

endmodule

// File: rtl/dbr_target.sv
module dbr_target #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4,
   parameter int OFS_W      = 16,
   parameter int JIDX_W     = 26
) (
   input  logic [XLEN-1:0]   npc_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [JIDX_W-1:0] idx_i,
   input  logic [XLEN-1:0]   reg_i,
   input  dbr_pkg::tsel_e    tsel_i,
   output logic [XLEN-1:0]   seq_o,
   output logic [XLEN-1:0]   tgt_o
);
   import dbr_pkg::*;

   localparam int SH     = $clog2(INSN_BYTES);
   localparam int SEXT_W = XLEN - OFS_W - SH;
   localparam int HOLD_W = XLEN - JIDX_W - SH;
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   logic [XLEN-1:0] rel_disp;
   logic [XLEN-1:0] rel_tgt;
   logic [XLEN-1:0] abs_tgt;
   logic [XLEN-1:0] reg_tgt;

   assign seq_o = npc_i + STEP;

   // displacement: sign extension only when the field is narrower than the address
   generate
      if (SEXT_W > 0) begin : g_sext
         assign rel_disp = {{SEXT_W{ofs_i[OFS_W-1]}}, ofs_i, {SH{1'b0}}};
      end else begin : g_nosext
         assign rel_disp = {ofs_i[XLEN-SH-1:0], {SH{1'b0}}};
      end
   endgenerate

   assign rel_tgt = npc_i + rel_disp;

   // absolute jump: keep the region bits of the delay-slot address if any remain
   generate
      if (HOLD_W > 0) begin : g_region
         assign abs_tgt = {npc_i[XLEN-1 -: HOLD_W], idx_i, {SH{1'b0}}};
      end else begin : g_flat
         assign abs_tgt = {idx_i, {SH{1'b0}}};
      end
   endgenerate

   assign reg_tgt = {reg_i[XLEN-1:SH], {SH{1'b0}}};

   always_comb begin
      case (tsel_i)
         TS_REL:  tgt_o = rel_tgt;
         TS_ABS:  tgt_o = abs_tgt;
         TS_REG:  tgt_o = reg_tgt;
         default: tgt_o = seq_o;
      endcase
   end

endmodule

// File: rtl/dbr_pc_regs.sv
module dbr_pc_regs #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] npc_d,
   output logic [XLEN-1:0] pc_q,
   output logic [XLEN-1:0] npc_q
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         npc_q <= RESET_PC + STEP;
      end else begin
         pc_q  <= npc_q;
         npc_q <= npc_d;
      end
   end

   // R1: leaving reset, the executing address is the reset address
   p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc_q == RESET_PC));

   // R2: the executing address always follows the previous nPC
   p_pc_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pc_q == $past(npc_q)));

endmodule

// File: rtl/dbr_pc_seq.sv
module dbr_pc_seq #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4,
   parameter int OFS_W      = 16,
   parameter int JIDX_W     = 26,
   parameter int REG_W      = 5,
   parameter int LINK_REG   = 31,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        xfer_op,
   input  logic [XLEN-1:0]   opnd_a,
   input  logic [XLEN-1:0]   opnd_b,
   input  logic [OFS_W-1:0]  br_ofs,
   input  logic [JIDX_W-1:0] jmp_idx,
   output logic [XLEN-1:0]   fetch_pc,
   output logic              link_we,
   output logic [XLEN-1:0]   link_val,
   output logic [REG_W-1:0]  link_rd
);
   import dbr_pkg::*;

   localparam int SH     = $clog2(INSN_BYTES);
   localparam int HOLD_W = XLEN - JIDX_W - SH;
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   // elaboration-time parameter checks
   generate
      if (INSN_BYTES < 2 || (1 << SH) != INSN_BYTES) begin : g_bad_step
         $error("INSN_BYTES must be a power of two of at least 2");
      end
      if (OFS_W + SH > XLEN) begin : g_bad_ofs
         $error("branch offset field does not fit the address");
      end
      if (JIDX_W + SH > XLEN) begin : g_bad_idx
         $error("jump index field does not fit the address");
      end
      if (LINK_REG < 0 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("LINK_REG not addressable with REG_W bits");
      end
   endgenerate

   tsel_e           tsel;
   logic            link_req;
   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] npc_q;
   logic [XLEN-1:0] npc_d;
   logic [XLEN-1:0] seq_addr;

   dbr_cond #(.XLEN(XLEN)) u_cond (
      .xfer_i (xfer_op),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .tsel_o (tsel),
      .link_o (link_req)
   );

   dbr_target #(
      .XLEN       (XLEN),
      .INSN_BYTES (INSN_BYTES),
      .OFS_W      (OFS_W),
      .JIDX_W     (JIDX_W)
   ) u_tgt (
      .npc_i  (npc_q),
      .ofs_i  (br_ofs),
      .idx_i  (jmp_idx),
      .reg_i  (opnd_a),
      .tsel_i (tsel),
      .seq_o  (seq_addr),
      .tgt_o  (npc_d)
   );

   dbr_pc_regs #(
      .XLEN       (XLEN),
      .INSN_BYTES (INSN_BYTES),
      .RESET_PC   (RESET_PC)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .npc_d (npc_d),
      .pc_q  (pc_q),
      .npc_q (npc_q)
   );

   assign fetch_pc = pc_q;
   assign link_we  = link_req;
   assign link_val = seq_addr;
   assign link_rd  = REG_W'(LINK_REG);

   // R2: without a redirect, nPC moves by exactly one instruction
   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tsel) == TS_SEQ) |-> (npc_q == $past(npc_q) + STEP));

   // R3: a taken less-or-equal-zero branch implies a zero or negative operand
   p_lez_test_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_op == XF_BLEZ && tsel == TS_REL) |-> (opnd_a == '0 || opnd_a[XLEN-1]));

   // R7: fetch addresses stay instruction-aligned
   p_fetch_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_pc[SH-1:0] == '0);

   // R6: absolute jumps preserve the region bits of nPC
   generate
      if (HOLD_W > 0) begin : g_region_chk
         p_jump_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(xfer_op) == XF_JABS || $past(xfer_op) == XF_JABSL))
            |-> (npc_q[XLEN-1 -: HOLD_W] == $past(npc_q[XLEN-1 -: HOLD_W])));
      end
   endgenerate

endmodule

// File: tb/sim_dbr_pc_seq.sv
module sim_dbr_pc_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  xfer_op = 4'd0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [15:0] br_ofs = '0;
   logic [25:0] jmp_idx = '0;
   logic [31:0] fetch_pc;
   logic        link_we;
   logic [31:0] link_val;
   logic [4:0]  link_rd;

   always #2.5 clk = ~clk;   // 200 MHz

   dbr_pc_seq #(
      .XLEN(32), .INSN_BYTES(4), .OFS_W(16), .JIDX_W(26),
      .REG_W(5), .LINK_REG(31), .RESET_PC(32'h0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .xfer_op(xfer_op), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .br_ofs(br_ofs), .jmp_idx(jmp_idx),
      .fetch_pc(fetch_pc), .link_we(link_we), .link_val(link_val),
      .link_rd(link_rd)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] m_pc;
   logic [31:0] m_npc;

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] ofs;
      logic [25:0] idx;
      logic [3:0]  req;
   } vec_t;

   localparam int N_VEC = 22;
   localparam vec_t TBL [N_VEC] = '{
      '{4'd0,  32'd0,          32'd0, 16'd0,     26'd0,         4'd2}, // R2 sequential
      '{4'd1,  32'd5,          32'd5, 16'd4,     26'd0,         4'd4}, // R4 equal taken
      '{4'd0,  32'd0,          32'd0, 16'd0,     26'd0,         4'd4}, // R4 delay slot
      '{4'd2,  32'd5,          32'd5, 16'd100,   26'd0,         4'd3}, // R3 not-equal not taken
      '{4'd3,  32'd0,          32'd0, 16'hFFFE,  26'd0,         4'd3}, // R3 zero boundary, backward
      '{4'd4,  32'd0,          32'd0, 16'd40,    26'd0,         4'd3}, // R3 >0 with zero: not taken
      '{4'd4,  32'd1,          32'd0, 16'd3,     26'd0,         4'd3}, // R3 >0 taken
      '{4'd5,  32'h8000_0000,  32'd0, 16'd8,     26'd0,         4'd3}, // R3 <0 most negative
      '{4'd6,  32'h8000_0000,  32'd0, 16'd8,     26'd0,         4'd3}, // R3 >=0 not taken
      '{4'd7,  32'd1,          32'd0, 16'd12,    26'd0,         4'd5}, // R5 link when not taken
      '{4'd8,  32'd0,          32'd0, 16'd6,     26'd0,         4'd5}, // R5 link and taken
      '{4'd0,  32'd0,          32'd0, 16'd0,     26'd0,         4'd2}, // R2
      '{4'd9,  32'd0,          32'd0, 16'd0,     26'h3FF_FFFF,  4'd6}, // R6 all-ones index
      '{4'd0,  32'd0,          32'd0, 16'd0,     26'd0,         4'd6}, // R6 delay slot
      '{4'd10, 32'd0,          32'd0, 16'd0,     26'h10,        4'd5}, // R5 jump with link
      '{4'd11, 32'h1234_5677,  32'd0, 16'd0,     26'd0,         4'd7}, // R7 misaligned register
      '{4'd1,  32'd1,          32'd1, 16'd2,     26'd0,         4'd8}, // R8 branch in slot
      '{4'd0,  32'd0,          32'd0, 16'd0,     26'd0,         4'd8}, // R8
      '{4'd12, 32'hFFFF_FFF2,  32'd0, 16'd0,     26'd0,         4'd7}, // R7 register jump with link
      '{4'd2,  32'd1,          32'd2, 16'h8000,  26'd0,         4'd4}, // R4 most negative offset in slot
      '{4'd15, 32'd3,          32'd3, 16'd9,     26'd7,         4'd9}, // R9 unused code
      '{4'd9,  32'd0,          32'd0, 16'd0,     26'd5,         4'd6}  // R6 region bits kept
   };

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic m_taken(input logic [3:0] op, input logic [31:0] a,
                                    input logic [31:0] b);
      case (op)
         4'd1:       return a == b;
         4'd2:       return a != b;
         4'd3:       return $signed(a) <= 0;
         4'd4:       return $signed(a) > 0;
         4'd5, 4'd7: return $signed(a) < 0;
         4'd6, 4'd8: return $signed(a) >= 0;
         default:    return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] m_next(input vec_t v, input logic [31:0] npc);
      case (v.op)
         4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8:
            return m_taken(v.op, v.a, v.b) ?
                   npc + {{14{v.ofs[15]}}, v.ofs, 2'b00} : npc + 32'd4;
         4'd9, 4'd10:  return {npc[31:28], v.idx, 2'b00};
         4'd11, 4'd12: return {v.a[31:2], 2'b00};
         default:      return npc + 32'd4;
      endcase
   endfunction

   task automatic run_vec(input vec_t v);
      logic exp_link;
      @(negedge clk);
      xfer_op = v.op; opnd_a = v.a; opnd_b = v.b; br_ofs = v.ofs; jmp_idx = v.idx;
      #1;
      exp_link = (v.op == 4'd7 || v.op == 4'd8 || v.op == 4'd10 || v.op == 4'd12);
      // R5 / R9: link request in the same cycle
      chk(exp_link ? 5 : 9, {31'd0, link_we}, {31'd0, exp_link}, "link_we");
      if (exp_link) begin
         chk(5, link_val, m_npc + 32'd4, "link_val");
         chk(5, {27'd0, link_rd}, 32'd31, "link_rd");
      end
      @(posedge clk);
      m_pc  = m_npc;
      m_npc = m_next(v, m_npc);
      #1;
      chk(int'(v.req), fetch_pc, m_pc, "fetch_pc");
   endtask

   task automatic reset_seq();
      @(negedge clk);
      rst_n = 1'b0;
      xfer_op = 4'd0;
      #1;
      chk(1, fetch_pc, 32'd0, "fetch_pc in reset");
      chk(9, {31'd0, link_we}, 32'd0, "link_we in reset");
      @(negedge clk);
      rst_n = 1'b1;
      m_pc  = 32'd0;
      m_npc = 32'd4;
      @(posedge clk);
      #1;
      chk(1, fetch_pc, 32'd4, "first step after reset");
      m_pc  = 32'd4;
      m_npc = 32'd8;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      reset_seq();
      for (int i = 0; i < N_VEC; i++) run_vec(TBL[i]);

      // R1: reset in the middle of a run, just after redirecting nPC
      run_vec('{4'd9, 32'd0, 32'd0, 16'd0, 26'h123, 4'd6});
      reset_seq();

      // R8: three transfers back to back, each taken
      run_vec('{4'd1, 32'd7, 32'd7, 16'd16, 26'd0, 4'd8});
      run_vec('{4'd11, 32'h0000_0400, 32'd0, 16'd0, 26'd0, 4'd8});
      run_vec('{4'd6, 32'd0, 32'd0, 16'hFFFF, 26'd0, 4'd8});
      run_vec('{4'd0, 32'd0, 32'd0, 16'd0, 26'd0, 4'd8});
      run_vec('{4'd0, 32'd0, 32'd0, 16'd0, 26'd0, 4'd2});

      // R9: unused codes 13 and 14 neither redirect nor link
      run_vec('{4'd13, 32'hFFFF_FFFF, 32'd0, 16'd1, 26'd1, 4'd9});
      run_vec('{4'd14, 32'd0, 32'd0, 16'hFFFF, 26'h3FF_FFFF, 4'd9});
      run_vec('{4'd0, 32'd0, 32'd0, 16'd0, 26'd0, 4'd2});

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual no completion expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule